// File: doc/BRIEF.md
# Power-On Strap Capture Unit

This block samples a small group of configuration pins once, at the moment the power-good input goes high, and holds what it saw for the rest of the power cycle. From those pins it derives a two-bit root-port configuration field, a top-swap flag and a two-bit firmware destination select. After the capture the pins return to their ordinary duty, and the block ignores any further movement on them.

The held values can be read through a compact register interface. The destination field and the top-swap flag can also be written. The top-swap flag has one exception: it cannot be cleared by software while the captured pin asked for it.

A companion address path steers firmware-window requests to one of three targets: SPI, PCI or LPC. When top swap is on, this path flips address bit 16 for requests that fall inside the window. A stability counter watches the pins ahead of the capture. If they were not held long enough, it raises a sticky flag.

Top module: `strap_capture_top`

## Requirements
- R1: After reset and before any power-good rising edge, the outputs hold their pull defaults: `rp_cfg`=00, `top_swap`=0, `boot_dest`=11, `cfg_err`=0 and `setup_err`=0, and all three route outputs are 0.
- R2: Pins are captured only in the cycle in which `pg` goes from 0 to 1. Pin changes at any other time leave `rp_cfg`, `top_swap` and `boot_dest` unchanged.
- R3: The captured `rp_cfg[0]` equals `strap_pc0_i`. The captured `rp_cfg[1]` equals `strap_pc1_i` when `strap_test_n_i` is 1, and is 0 otherwise.
- R4: The captured `top_swap` is the inverse of `strap_swap_n_i`. While `top_swap` is 1, a valid request inside the window [`FW_BASE`, `FW_LIMIT`] leaves on `fw_addr` with bit 16 inverted.
- R5: When the swap pin was captured low, a software write of 0 to the swap register does not clear `top_swap`. A later power-good rising edge with the pin high clears it. When the pin was captured high, software can set and clear the bit freely.
- R6: `boot_dest` is captured as {`strap_dest_i[1]`, `strap_dest_i[0]`}, bit 1 being the MSB. A valid in-window request raises exactly one route: 01 selects `route_spi`, 10 selects `route_pci` and 11 selects `route_lpc`.
- R7: Software can rewrite `boot_dest` at register 1, bits 1:0. The routing follows the written value from the next cycle on.
- R8: The value 00, whether captured or written, routes to LPC and sets `cfg_err`. `cfg_err` stays set until reset.
- R9: All routes are 0 while the registered power-good level is low, and also for requests outside the window. Requests outside the window pass through to `fw_addr` unchanged.
- R10: If the pins were stable for at least `SETUP_CYC` clock periods before the capture edge, `setup_err` stays 0. A shorter hold still captures the pins but sets `setup_err`, which stays set until reset.
- R11: The register map is as follows, with unused bits reading 0:
  - address 0: `rp_cfg` in bits 1:0, read-only
  - address 1: `boot_dest` in bits 1:0
  - address 2: `top_swap` in bit 0
  - address 3: `cfg_err` in bit 0 and `setup_err` in bit 1, read-only

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg | input | 1 | Power-good level, synchronous to clk |
| strap_pc1_i | input | 1 | Root-port configuration pin, bit 1 |
| strap_pc0_i | input | 1 | Root-port configuration pin, bit 0 |
| strap_test_n_i | input | 1 | Test pin; when low, bit 1 keeps its default |
| strap_swap_n_i | input | 1 | Active-low top-swap pin |
| strap_dest_i | input | 2 | Firmware destination pins, bit 1 is the MSB |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| req_valid | input | 1 | Address request valid |
| req_addr | input | AW | Request address |
| fw_addr | output | AW | Forwarded address, bit 16 possibly inverted |
| route_spi | output | 1 | Request steered to SPI |
| route_pci | output | 1 | Request steered to PCI |
| route_lpc | output | 1 | Request steered to LPC |
| rp_cfg | output | 2 | Captured root-port configuration |
| top_swap | output | 1 | Effective top-swap flag |
| boot_dest | output | 2 | Effective firmware destination field |
| cfg_err | output | 1 | Sticky reserved-encoding flag |
| setup_err | output | 1 | Sticky short-setup flag |

## Verification
The bench sweeps all 64 pin combinations through a capture with the setup window held to exactly its minimum. A design that decoded the test-pin gating, the destination bit order or the swap polarity wrongly would miss on some of these patterns. The bench also shortens the setup by one cycle: a counter that is off by one would either stay silent or flag the legal case as well. It also checks the following:
- pins wiggled after capture, which a level-sensitive latch would follow;
- a software clear of a pin-locked swap bit, which a plain read/write register would accept;
- the window edges, where a wrong comparison would flip or steer addresses just outside the window.

// File: rtl/strap_pkg.sv
package strap_pkg;

  localparam int RAW = 2;

  localparam logic [RAW-1:0] RA_PORT = 2'd0;
  localparam logic [RAW-1:0] RA_BOOT = 2'd1;
  localparam logic [RAW-1:0] RA_SWAP = 2'd2;
  localparam logic [RAW-1:0] RA_STAT = 2'd3;

  localparam logic [1:0] DEST_RSVD = 2'b00;
  localparam logic [1:0] DEST_SPI  = 2'b01;
  localparam logic [1:0] DEST_PCI  = 2'b10;
  localparam logic [1:0] DEST_LPC  = 2'b11;

  typedef struct packed {
    logic       pc1;
    logic       pc0;
    logic       test_n;
    logic       swap_n;
    logic [1:0] dest;
  } strap_t;

  // Pin levels implied by the board pulls when nothing drives the pins.
  localparam strap_t STRAP_PULL_DEFAULT = '{pc1: 1'b0, pc0: 1'b0, test_n: 1'b1,
                                            swap_n: 1'b1, dest: DEST_LPC};

  // Root-port field: bit 1 honours its pin only when the test pin is high.
  function automatic logic [1:0] rp_decode(strap_t s);
    return {s.test_n & s.pc1, s.pc0};
  endfunction

  // Route vector ordered {spi, pci, lpc}; the reserved code falls back to LPC.
  function automatic logic [2:0] route_decode(logic [1:0] d);
    logic [2:0] r;
    case (d)
      DEST_SPI: r = 3'b100;
      DEST_PCI: r = 3'b010;
      default:  r = 3'b001;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/strap_edge_stab.sv
module strap_edge_stab
  import strap_pkg::*;
#(
  parameter int SETUP_CYC = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pg,
  input  strap_t straps,
  output logic   pg_level,
  output logic   pg_rise,
  output logic   setup_bad
);

  localparam int CW = (SETUP_CYC > 2) ? $clog2(SETUP_CYC) : 1;
  localparam logic [CW-1:0] LIM = CW'(SETUP_CYC - 1);

  logic          pg_q;
  strap_t        prev_q;
  logic [CW-1:0] stable_q;
  logic          same_now;

  assign same_now  = (straps == prev_q);
  assign pg_rise   = pg & ~pg_q;
  assign pg_level  = pg_q;
  assign setup_bad = pg_rise & (~same_now | (stable_q < LIM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q     <= 1'b0;
      prev_q   <= STRAP_PULL_DEFAULT;
      stable_q <= '0;
    end else begin
      pg_q   <= pg;
      prev_q <= straps;
      if (!same_now)
        stable_q <= '0;
      else if (stable_q != LIM)
        stable_q <= stable_q + 1'b1;
    end
  end

endmodule

// File: rtl/strap_cfg_regs.sv
module strap_cfg_regs
  import strap_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap,
  input  logic           setup_bad,
  input  strap_t         straps,
  input  logic           we,
  input  logic [RAW-1:0] addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic [1:0]     rp_cfg,
  output logic           swap_bit,
  output logic           swap_lock,
  output logic [1:0]     dest,
  output logic           cfg_err,
  output logic           setup_err
);

  logic unused_wdata;
  assign unused_wdata = ^wdata[DW-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_cfg    <= rp_decode(STRAP_PULL_DEFAULT);
      swap_bit  <= ~STRAP_PULL_DEFAULT.swap_n;
      swap_lock <= ~STRAP_PULL_DEFAULT.swap_n;
      dest      <= STRAP_PULL_DEFAULT.dest;
      cfg_err   <= 1'b0;
      setup_err <= 1'b0;
    end else if (cap) begin
      rp_cfg    <= rp_decode(straps);
      swap_bit  <= ~straps.swap_n;
      swap_lock <= ~straps.swap_n;
      dest      <= straps.dest;
      if (straps.dest == DEST_RSVD) cfg_err <= 1'b1;
      if (setup_bad) setup_err <= 1'b1;
    end else if (we) begin
      case (addr)
        RA_BOOT: begin
          dest <= wdata[1:0];
          if (wdata[1:0] == DEST_RSVD) cfg_err <= 1'b1;
        end
        RA_SWAP: swap_bit <= wdata[0] | swap_lock;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_PORT: rdata[1:0] = rp_cfg;
      RA_BOOT: rdata[1:0] = dest;
      RA_SWAP: rdata[0]   = swap_bit;
      RA_STAT: rdata[1:0] = {setup_err, cfg_err};
      default: ;
    endcase
  end

endmodule

// File: rtl/strap_fw_router.sv
module strap_fw_router
  import strap_pkg::*;
#(
  parameter int          AW       = 32,
  parameter logic [AW-1:0] FW_BASE  = 32'hFFE0_0000,
  parameter logic [AW-1:0] FW_LIMIT = 32'hFFEF_FFFF,
  parameter int          FLIP_BIT = 16
) (
  input  logic          en,
  input  logic          swap,
  input  logic [1:0]    dest,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic [AW-1:0] fw_addr,
  output logic          in_win,
  output logic          route_spi,
  output logic          route_pci,
  output logic          route_lpc
);

  localparam logic [AW-1:0] FLIP_MASK = {{(AW-1){1'b0}}, 1'b1} << FLIP_BIT;

  logic [2:0] rvec;

  assign in_win  = req_valid && (req_addr >= FW_BASE) && (req_addr <= FW_LIMIT);
  assign fw_addr = (in_win && swap) ? (req_addr ^ FLIP_MASK) : req_addr;
  assign rvec    = (in_win && en) ? route_decode(dest) : 3'b000;

  assign route_spi = rvec[2];
  assign route_pci = rvec[1];
  assign route_lpc = rvec[0];

endmodule

// File: rtl/strap_capture_top.sv
module strap_capture_top
  import strap_pkg::*;
#(
  parameter int            DW        = 16,
  parameter int            AW        = 32,
  parameter int            SETUP_CYC = 4,
  parameter logic [AW-1:0] FW_BASE   = 32'hFFE0_0000,
  parameter logic [AW-1:0] FW_LIMIT  = 32'hFFEF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pg,
  input  logic          strap_pc1_i,
  input  logic          strap_pc0_i,
  input  logic          strap_test_n_i,
  input  logic          strap_swap_n_i,
  input  logic [1:0]    strap_dest_i,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic [AW-1:0] fw_addr,
  output logic          route_spi,
  output logic          route_pci,
  output logic          route_lpc,
  output logic [1:0]    rp_cfg,
  output logic          top_swap,
  output logic [1:0]    boot_dest,
  output logic          cfg_err,
  output logic          setup_err
);

  strap_t pins;
  logic   pg_level, pg_rise, setup_bad, swap_lock, in_win;

  assign pins = '{pc1: strap_pc1_i, pc0: strap_pc0_i, test_n: strap_test_n_i,
                  swap_n: strap_swap_n_i, dest: strap_dest_i};

  strap_edge_stab #(.SETUP_CYC(SETUP_CYC)) u_edge (
    .clk(clk), .rst_n(rst_n), .pg(pg), .straps(pins),
    .pg_level(pg_level), .pg_rise(pg_rise), .setup_bad(setup_bad)
  );

  strap_cfg_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cap(pg_rise), .setup_bad(setup_bad),
    .straps(pins), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .rp_cfg(rp_cfg), .swap_bit(top_swap),
    .swap_lock(swap_lock), .dest(boot_dest), .cfg_err(cfg_err),
    .setup_err(setup_err)
  );

  strap_fw_router #(.AW(AW), .FW_BASE(FW_BASE), .FW_LIMIT(FW_LIMIT)) u_route (
    .en(pg_level), .swap(top_swap), .dest(boot_dest),
    .req_valid(req_valid), .req_addr(req_addr), .fw_addr(fw_addr),
    .in_win(in_win), .route_spi(route_spi), .route_pci(route_pci),
    .route_lpc(route_lpc)
  );

endmodule

// File: rtl/strap_capture_chk.sv
module strap_capture_chk
  import strap_pkg::*;
#(
  parameter int            AW      = 32,
  parameter logic [AW-1:0] FW_BASE = 32'hFFE0_0000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pg_rise,
  input logic          pg_level,
  input logic          swap_lock,
  input logic          strap_swap_n_i,
  input logic [1:0]    strap_dest_i,
  input logic          reg_we,
  input logic [1:0]    reg_addr,
  input logic          top_swap,
  input logic [1:0]    boot_dest,
  input logic          cfg_err,
  input logic          setup_err,
  input logic [AW-1:0] req_addr,
  input logic [AW-1:0] fw_addr,
  input logic          route_spi,
  input logic          route_pci,
  input logic          route_lpc
);

  // R2
  boot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pg_rise && !(reg_we && reg_addr == RA_BOOT)) |=> $stable(boot_dest));

  // R6
  boot_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_rise |=> (boot_dest == $past(strap_dest_i)));

  // R6
  route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({route_spi, route_pci, route_lpc}));

  // R4
  swap_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_rise |=> (top_swap == !$past(strap_swap_n_i)));

  // R5
  swap_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_lock && !pg_rise) |=> top_swap);

  // R8
  cfg_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R10
  setup_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_err |=> setup_err);

  // R9
  dark_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_level |-> ({route_spi, route_pci, route_lpc} == 3'b000));

  // R9
  below_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr < FW_BASE) |-> (fw_addr == req_addr && !route_spi && !route_pci && !route_lpc));

endmodule

bind strap_capture_top strap_capture_chk #(.AW(AW), .FW_BASE(FW_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .pg_rise(pg_rise), .pg_level(pg_level),
  .swap_lock(swap_lock), .strap_swap_n_i(strap_swap_n_i),
  .strap_dest_i(strap_dest_i), .reg_we(reg_we), .reg_addr(reg_addr),
  .top_swap(top_swap), .boot_dest(boot_dest), .cfg_err(cfg_err),
  .setup_err(setup_err), .req_addr(req_addr), .fw_addr(fw_addr),
  .route_spi(route_spi), .route_pci(route_pci), .route_lpc(route_lpc)
);

// File: tb/strap_capture_top_tb.sv
module strap_capture_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pg = 1'b0;
  logic        pc1 = 1'b0, pc0 = 1'b0, test_n = 1'b1, swap_n = 1'b1;
  logic [1:0]  dpins = 2'b11;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] fw_addr;
  logic        route_spi, route_pci, route_lpc;
  logic [1:0]  rp_cfg, boot_dest;
  logic        top_swap, cfg_err, setup_err;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  strap_capture_top u_dut (
    .clk(clk), .rst_n(rst_n), .pg(pg), .strap_pc1_i(pc1), .strap_pc0_i(pc0),
    .strap_test_n_i(test_n), .strap_swap_n_i(swap_n), .strap_dest_i(dpins),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .req_valid(req_valid), .req_addr(req_addr),
    .fw_addr(fw_addr), .route_spi(route_spi), .route_pci(route_pci),
    .route_lpc(route_lpc), .rp_cfg(rp_cfg), .top_swap(top_swap),
    .boot_dest(boot_dest), .cfg_err(cfg_err), .setup_err(setup_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_route(input logic [1:0] d);
    if (d == 2'b01) return 3'b100;
    if (d == 2'b10) return 3'b010;
    return 3'b001;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pg = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_pins(input logic [5:0] v);
    {pc1, pc0, test_n, swap_n, dpins} = v;
  endtask

  // Pins already applied at the current negedge; raise power-good after hold periods.
  task automatic raise_pg(input int hold);
    repeat (hold) @(negedge clk);
    pg = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin : watchdog
    #(200000 * 10);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [15:0] rv;
    // R1 reset state
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b1; req_addr = 32'hFFE5_1234;
    @(negedge clk);
    chk("R1", "rp_cfg", {30'd0, rp_cfg}, 32'd0);
    chk("R1", "top_swap", {31'd0, top_swap}, 32'd0);
    chk("R1", "boot_dest", {30'd0, boot_dest}, 32'd3);
    chk("R1", "errs", {30'd0, setup_err, cfg_err}, 32'd0);
    chk("R1", "routes", {29'd0, route_spi, route_pci, route_lpc}, 32'd0);

    // Sweep every pin pattern with the minimum legal setup hold
    for (int v = 0; v < 64; v++) begin
      logic [5:0] p;
      logic [1:0] erp;
      logic [31:0] efw;
      p = v[5:0];
      do_reset();
      set_pins(p);
      raise_pg(4);
      erp = {p[3] & p[5], p[4]};
      chk("R3", "rp_cfg", {30'd0, rp_cfg}, {30'd0, erp});
      chk("R4", "top_swap", {31'd0, top_swap}, {31'd0, ~p[2]});
      chk("R6", "boot_dest", {30'd0, boot_dest}, {30'd0, p[1:0]});
      chk("R6", "route", {29'd0, route_spi, route_pci, route_lpc}, {29'd0, exp_route(p[1:0])});
      chk("R8", "cfg_err", {31'd0, cfg_err}, {31'd0, p[1:0] == 2'b00});
      chk("R10", "setup_err at min hold", {31'd0, setup_err}, 32'd0);
      efw = ~p[2] ? 32'hFFE4_1234 : 32'hFFE5_1234;
      chk("R4", "fw_addr", fw_addr, efw);
      // R2 pins move after capture
      set_pins(~p);
      @(negedge clk); @(negedge clk);
      chk("R2", "rp_cfg held", {30'd0, rp_cfg}, {30'd0, erp});
      chk("R2", "swap held", {31'd0, top_swap}, {31'd0, ~p[2]});
      chk("R2", "dest held", {30'd0, boot_dest}, {30'd0, p[1:0]});
    end

    // R10 one period short of the setup window
    do_reset();
    set_pins(6'b110110);
    raise_pg(3);
    chk("R10", "setup_err short", {31'd0, setup_err}, 32'd1);
    chk("R10", "value still captured", {30'd0, boot_dest}, 32'd2);
    rd(2'd3, rv);
    chk("R11", "status read", {16'd0, rv}, 32'd2);

    // R5 locked swap
    do_reset();
    set_pins(6'b011011);
    raise_pg(4);
    chk("R5", "swap captured", {31'd0, top_swap}, 32'd1);
    wr(2'd2, 16'h0000);
    chk("R5", "clear ignored", {31'd0, top_swap}, 32'd1);
    rd(2'd2, rv);
    chk("R11", "swap read", {16'd0, rv}, 32'd1);
    // R9 power-good low darkens routes
    pg = 1'b0;
    swap_n = 1'b1;
    @(negedge clk);
    chk("R9", "routes while pg low", {29'd0, route_spi, route_pci, route_lpc}, 32'd0);
    raise_pg(4);
    chk("R5", "fresh cycle clears", {31'd0, top_swap}, 32'd0);
    wr(2'd2, 16'h0001);
    chk("R5", "sw set", {31'd0, top_swap}, 32'd1);
    wr(2'd2, 16'h0000);
    chk("R5", "sw clear", {31'd0, top_swap}, 32'd0);

    // R7 destination rewrite
    wr(2'd1, 16'h0001);
    chk("R7", "spi route", {29'd0, route_spi, route_pci, route_lpc}, 32'd4);
    rd(2'd1, rv);
    chk("R11", "dest read", {16'd0, rv}, 32'd1);
    wr(2'd1, 16'h0002);
    chk("R7", "pci route", {29'd0, route_spi, route_pci, route_lpc}, 32'd2);
    chk("R8", "no err yet", {31'd0, cfg_err}, 32'd0);
    wr(2'd1, 16'h0000);
    chk("R8", "reserved to lpc", {29'd0, route_spi, route_pci, route_lpc}, 32'd1);
    chk("R8", "err set", {31'd0, cfg_err}, 32'd1);
    wr(2'd1, 16'h0003);
    chk("R8", "err sticky", {31'd0, cfg_err}, 32'd1);
    rd(2'd0, rv);
    chk("R11", "port read", {16'd0, rv}, {30'd0, rp_cfg});

    // R9 window edges with swap on
    wr(2'd2, 16'h0001);
    req_addr = 32'hFFDF_FFFF; #1;
    chk("R9", "below window addr", fw_addr, 32'hFFDF_FFFF);
    chk("R9", "below window route", {29'd0, route_spi, route_pci, route_lpc}, 32'd0);
    req_addr = 32'hFFE0_0000; #1;
    chk("R4", "window base flipped", fw_addr, 32'hFFE1_0000);
    req_addr = 32'hFFF0_0000; #1;
    chk("R9", "above window addr", fw_addr, 32'hFFF0_0000);
    chk("R9", "above window route", {29'd0, route_spi, route_pci, route_lpc}, 32'd0);
    req_valid = 1'b0; req_addr = 32'hFFE5_0000; #1;
    chk("R9", "invalid no route", {29'd0, route_spi, route_pci, route_lpc}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule